// File: doc/BRIEF.md
# Four-Stage Reconfigurable Pipeline Register

This block keeps four data-wide registers, called stage 1 to stage 4, behind one write port and one read port. A two-bit operation code, sampled at every rising clock edge, decides how the stages load. The four stages can act as one delay line four deep. They can also act as two independent pipes two deep, where stages 1 and 2 form the upper pair and stages 3 and 4 form the lower pair. A third choice freezes all four stages. Every load uses the values the stages held before the edge.

A two-bit read select steers any one stage to the read port through a purely combinational multiplexer, so a read never waits for a clock. Reads and writes are fully independent, and one stage can be read while another is written. The read result is offered as a data word plus a drive flag that follows an active-low output enable. A three-state bus is also provided for boards that share the line.

The parameter `PAIR_SHIFT` selects one of two build variants. When a split load writes the head of a pair (stage 1 or stage 3), the value 1 makes the pair's tail take the head's previous value. The value 0 leaves the tail unchanged.

Top module: `mlpr_top`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge clears all four stages to zero, whatever `op` and `din` hold in that cycle.
- R2: With `op` = 2'b00 (chain), one edge moves `din` into stage 1, stage 1 into stage 2, stage 2 into stage 3 and stage 3 into stage 4.
- R3: With `op` = 2'b01 (lower load), one edge writes `din` into stage 3, and stages 1 and 2 keep their values.
- R4: With `op` = 2'b10 (upper load), one edge writes `din` into stage 1, and stages 3 and 4 keep their values.
- R5: When `PAIR_SHIFT` = 1, a lower load copies the old stage 3 into stage 4, and an upper load copies the old stage 1 into stage 2.
- R6: When `PAIR_SHIFT` = 0, a lower load leaves stage 4 unchanged, and an upper load leaves stage 2 unchanged.
- R7: With `op` = 2'b11 (freeze), no stage changes at the edge.
- R8: `rd_data` shows stage 4 when `sel` = 2'b00, stage 3 for 2'b01, stage 2 for 2'b10 and stage 1 for 2'b11. It follows a change of `sel` with no clock edge.
- R9: When `oe_n` = 0, `rd_drive` = 1 and `q_bus` equals `rd_data`. When `oe_n` = 1, `rd_drive` = 0 and `q_bus` is released to high impedance.
- R10: `sel` and `oe_n` have no effect on any stage. A read of any stage in the same cycle as a write reports the value written at the most recent edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear of all stages |
| op | input | 2 | Load operation: 00 chain, 01 lower load, 10 upper load, 11 freeze |
| sel | input | 2 | Read select: 00 stage 4, 01 stage 3, 10 stage 2, 11 stage 1 |
| din | input | W | Write data |
| oe_n | input | 1 | Active-low output enable |
| rd_data | output | W | Selected stage, combinational |
| rd_drive | output | 1 | High when the read port should drive |
| q_bus | output | W | Three-state copy of `rd_data` |

## Verification
A write to one stage and a read of any stage can fall in the same cycle. A read select can also change while the write operation for the next edge is already on the inputs. The sweep runs every ordered pair of operations, repeated with arithmetic data patterns, on both variants at once. After each edge it steps `sel` through all four codes before the next edge, and it compares every read with a model of the four stages built in the bench. Between edges the output enable is toggled and `sel` is varied. The next comparison then shows whether either one disturbed a stage.

// File: rtl/mlpr_pkg.sv
package mlpr_pkg;

    localparam int STAGES   = 4;
    localparam int PAIR_LEN = 2;
    localparam int PAIRS    = STAGES / PAIR_LEN;

    typedef enum logic [1:0] {
        OP_CHAIN  = 2'b00,
        OP_LOWER  = 2'b01,
        OP_UPPER  = 2'b10,
        OP_FREEZE = 2'b11
    } op_e;

    // per-stage load control
    typedef struct packed {
        logic en;
        logic from_din;
    } stage_ctl_t;

    // select code 00 picks the last stage, 11 picks the first
    function automatic logic [1:0] sel_to_stage(input logic [1:0] s);
        return 2'd3 - s;
    endfunction

    // pair written by a split load
    function automatic int unsigned split_target(input op_e o);
        return (o == OP_UPPER) ? 0 : 1;
    endfunction

endpackage

// File: rtl/mlpr_op_decode.sv
module mlpr_op_decode
    import mlpr_pkg::*;
#(
    parameter bit PAIR_SHIFT = 1'b1
) (
    input  logic [1:0]                    op,
    output stage_ctl_t [STAGES-1:0]       ctl
);

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam bit          IS_HEAD = (k % PAIR_LEN) == 0;
        localparam int unsigned PAIR_ID = k / PAIR_LEN;

        stage_ctl_t c;

        always_comb begin
            c = '0;
            unique case (op_e'(op))
                OP_CHAIN: begin
                    c.en       = 1'b1;
                    c.from_din = (k == 0);
                end
                OP_LOWER, OP_UPPER: begin
                    if (split_target(op_e'(op)) == PAIR_ID) begin
                        if (IS_HEAD) begin
                            c.en       = 1'b1;
                            c.from_din = 1'b1;
                        end else begin
                            c.en       = PAIR_SHIFT;
                            c.from_din = 1'b0;
                        end
                    end
                end
                default: c = '0;
            endcase
        end

        assign ctl[k] = c;
    end

endmodule

// File: rtl/mlpr_stage_bank.sv
module mlpr_stage_bank
    import mlpr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  stage_ctl_t [STAGES-1:0]       ctl,
    input  logic [W-1:0]                  din,
    output logic [STAGES-1:0][W-1:0]      q
);

    for (genvar k = 0; k < STAGES; k++) begin : g_reg
        logic [W-1:0] upstream;
        logic [W-1:0] r;

        if (k == 0) begin : g_first
            assign upstream = din;
        end else begin : g_rest
            assign upstream = q[k-1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                r <= '0;
            end else if (ctl[k].en) begin
                r <= ctl[k].from_din ? din : upstream;
            end
        end

        assign q[k] = r;
    end

endmodule

// File: rtl/mlpr_read_mux.sv
module mlpr_read_mux
    import mlpr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [STAGES-1:0][W-1:0] q,
    input  logic [1:0]               sel,
    output logic [W-1:0]             rd_data
);

    always_comb begin
        rd_data = q[sel_to_stage(sel)];
    end

endmodule

// File: rtl/mlpr_top.sv
module mlpr_top
    import mlpr_pkg::*;
#(
    parameter int W          = 16,
    parameter bit PAIR_SHIFT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   op,
    input  logic [1:0]   sel,
    input  logic [W-1:0] din,
    input  logic         oe_n,
    output logic [W-1:0] rd_data,
    output logic         rd_drive,
    output logic [W-1:0] q_bus
);

    stage_ctl_t [STAGES-1:0]  ctl;
    logic [STAGES-1:0][W-1:0] stage_q;

    mlpr_op_decode #(.PAIR_SHIFT(PAIR_SHIFT)) u_dec (
        .op  (op),
        .ctl (ctl)
    );

    mlpr_stage_bank #(.W(W)) u_bank (
        .clk (clk),
        .rst (rst),
        .ctl (ctl),
        .din (din),
        .q   (stage_q)
    );

    mlpr_read_mux #(.W(W)) u_mux (
        .q       (stage_q),
        .sel     (sel),
        .rd_data (rd_data)
    );

    assign rd_drive = ~oe_n;
    assign q_bus    = rd_drive ? rd_data : {W{1'bz}};

endmodule

// File: rtl/mlpr_checker.sv
module mlpr_checker #(
    parameter int W          = 16,
    parameter bit PAIR_SHIFT = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        op,
    input logic [1:0]        sel,
    input logic [W-1:0]      din,
    input logic [W-1:0]      rd_data,
    input logic [3:0][W-1:0] stage_q
);

    logic prev_rst;

    always_ff @(posedge clk) begin
        prev_rst <= rst;
        // R1
        if (prev_rst) begin
            rst_clear_chk: assert (stage_q == '0);
        end
    end

    // R2
    chain_shift_chk: assert property (@(posedge clk) disable iff (rst)
        op == 2'b00 |=> stage_q[0] == $past(din) && stage_q[1] == $past(stage_q[0])
                     && stage_q[2] == $past(stage_q[1]) && stage_q[3] == $past(stage_q[2]));

    // R3
    lower_load_chk: assert property (@(posedge clk) disable iff (rst)
        op == 2'b01 |=> stage_q[2] == $past(din) && $stable(stage_q[0]) && $stable(stage_q[1]));

    // R4
    upper_load_chk: assert property (@(posedge clk) disable iff (rst)
        op == 2'b10 |=> stage_q[0] == $past(din) && $stable(stage_q[2]) && $stable(stage_q[3]));

    // R5
    tail_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (PAIR_SHIFT && op == 2'b10) |=> stage_q[1] == $past(stage_q[0]));

    // R6
    tail_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!PAIR_SHIFT && op == 2'b01) |=> $stable(stage_q[3]));

    // R7
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        op == 2'b11 |=> $stable(stage_q));

    // R8
    read_first_chk: assert property (@(posedge clk) disable iff (rst)
        sel == 2'b11 |-> rd_data == stage_q[0]);

    // R8
    read_last_chk: assert property (@(posedge clk) disable iff (rst)
        sel == 2'b00 |-> rd_data == stage_q[3]);

endmodule

bind mlpr_top mlpr_checker #(.W(W), .PAIR_SHIFT(PAIR_SHIFT)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .sel     (sel),
    .din     (din),
    .rd_data (rd_data),
    .stage_q (stage_q)
);

// File: tb/tb_mlpr_top.sv
`timescale 1ns/10ps
module tb_mlpr_top;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   op;
    logic [1:0]   sel;
    logic [W-1:0] din;
    logic         oe_n;
    logic [W-1:0] rd_a, rd_b, bus_a, bus_b;
    logic         drv_a, drv_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0] ma [4];
    logic [W-1:0] mb [4];

    always #4 clk = ~clk;

    mlpr_top #(.W(W), .PAIR_SHIFT(1'b1)) dut (
        .clk(clk), .rst(rst), .op(op), .sel(sel), .din(din), .oe_n(oe_n),
        .rd_data(rd_a), .rd_drive(drv_a), .q_bus(bus_a)
    );

    mlpr_top #(.W(W), .PAIR_SHIFT(1'b0)) dut_b (
        .clk(clk), .rst(rst), .op(op), .sel(sel), .din(din), .oe_n(oe_n),
        .rd_data(rd_b), .rd_drive(drv_b), .q_bus(bus_b)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [1:0] o, input bit variant_a);
        case (o)
            2'b00: return "R2";
            2'b01: return variant_a ? "R3/R5" : "R3/R6";
            2'b10: return variant_a ? "R4/R5" : "R4/R6";
            default: return "R7";
        endcase
    endfunction

    // model update from the requirements; index 0 is stage 1
    task automatic model_edge(input logic r, input logic [1:0] o, input logic [W-1:0] d);
        logic [W-1:0] pa [4];
        logic [W-1:0] pb [4];
        pa = ma; pb = mb;
        if (r) begin
            for (int i = 0; i < 4; i++) begin ma[i] = '0; mb[i] = '0; end
        end else begin
            case (o)
                2'b00: begin
                    ma[0] = d; ma[1] = pa[0]; ma[2] = pa[1]; ma[3] = pa[2];
                    mb[0] = d; mb[1] = pb[0]; mb[2] = pb[1]; mb[3] = pb[2];
                end
                2'b01: begin
                    ma[2] = d; ma[3] = pa[2];
                    mb[2] = d;
                end
                2'b10: begin
                    ma[0] = d; ma[1] = pa[0];
                    mb[0] = d;
                end
                default: ;
            endcase
        end
    endtask

    // R8 R10: sweep every read select after an edge
    task automatic read_all(input string req);
        for (int s = 0; s < 4; s++) begin
            #0.25 sel = 2'(s);
            #0.25;
            check({req, " R8"}, rd_a, ma[3 - s]);
            check({req, " R8"}, rd_b, mb[3 - s]);
        end
    endtask

    task automatic step(input logic r, input logic [1:0] o, input logic [W-1:0] d);
        @(negedge clk);
        rst = r; op = o; din = d;
        sel = 2'(d[1:0]);
        @(posedge clk);
        model_edge(r, o, d);
        read_all(r ? "R1" : req_of(o, 1'b1));
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; op = 2'b00; sel = 2'b00; din = 16'hBEEF; oe_n = 1'b0;
        for (int i = 0; i < 4; i++) begin ma[i] = 'x; mb[i] = 'x; end
        // R1: reset wins over a chain load with nonzero data
        step(1'b1, 2'b00, 16'hBEEF);
        step(1'b1, 2'b10, 16'h1234);

        // fill so that every stage differs
        step(1'b0, 2'b00, 16'h0101);
        step(1'b0, 2'b00, 16'h0202);
        step(1'b0, 2'b00, 16'h0303);
        step(1'b0, 2'b00, 16'h0404);

        // every ordered pair of operations, several data patterns
        for (int rep = 0; rep < 4; rep++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    step(1'b0, 2'(a), 16'(16'h1357 * (rep * 16 + a * 4 + b + 1) ^ (rep << 12)));
                    step(1'b0, 2'(b), 16'(16'hFFFF - 16'h0F1E * (a + b + rep)));
                end
            end
        end

        // R9 R10: enable and select wiggles between edges do not touch stages
        @(negedge clk);
        op = 2'b11;
        oe_n = 1'b1;
        for (int s = 0; s < 4; s++) begin
            #0.25 sel = 2'(s);
            #0.25;
            checks++;
            if (drv_a !== 1'b0 || drv_b !== 1'b0) begin
                fails++;
                $display("FAIL R9: actual drive %b/%b expected 0", drv_a, drv_b);
            end
        end
        @(posedge clk);
        model_edge(1'b0, 2'b11, din);
        #0.25 oe_n = 1'b0;
        #0.25;
        checks++;
        if (drv_a !== 1'b1 || drv_b !== 1'b1) begin
            fails++;
            $display("FAIL R9: actual drive %b/%b expected 1", drv_a, drv_b);
        end
        for (int s = 0; s < 4; s++) begin
            #0.25 sel = 2'(s);
            #0.25;
            check("R9", bus_a, ma[3 - s]);
            check("R9", bus_b, mb[3 - s]);
            check("R10", rd_a, ma[3 - s]);
        end

        // R1 again after activity
        step(1'b1, 2'b01, 16'hA5A5);
        step(1'b0, 2'b11, 16'h5A5A);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule